// File: doc/BRIEF.md
# Display Pixel Bus Packer

The block turns a ready/valid stream of pixels into a sequence of word writes on a parallel display data bus of up to 16 lines. It handles several cycle formats, each meaning a fixed number of bus cycles per pixel (or per pair of pixels). Every word it produces is handed to an external strobe sequencer through a request/acknowledge pair: the packer holds `bus_req` high with stable data and select until the sequencer pulses `bus_ack` to say the write cycle is complete. The packer does not generate strobe edges itself.

A frame is started by pulsing `frame_start`. This samples the pixel total and the cycle format and raises the enable flag `frame_en`. Once that many pixels have gone out and the last write cycle has been acknowledged, the block drops `frame_en` by itself and pulses `frame_done`. While no frame is running, single command words or parameter words can be written through a separate port. The select line `bus_dc` tells the display which kind each word is.

Top module: `pixbus_packer`

## Requirements
- R1: With format code 0 (1:1), every pixel gives exactly one bus word, equal to pixel bits 15:0.
- R2: With format code 1 (2:1), every pixel gives two words: first pixel bits 15:8, then pixel bits 7:0. Each byte sits on bus bits 7:0 and bus bits 15:8 are zero.
- R3: With format code 2 (3:1), every pixel gives three words carrying pixel bits 23:16, then 15:8, then 7:0. Each byte sits on bus bits 7:0 and bus bits 15:8 are zero.
- R4: With format code 3 (3:2), each pair of pixels A, B gives three words, in this order: A[23:8], then {A[7:0], B[23:16]}, then B[15:0].
- R5: In format 3, if the frame has an odd pixel total, the last pixel gives two words: its bits 23:8, then {its bits 7:0, 8'h00}.
- R6: A frame consumes exactly the sampled pixel total from the stream and no more. A total of zero finishes the frame without any bus write.
- R7: After the last write of a frame is acknowledged, `frame_en` falls and `frame_done` is high for exactly one cycle. No bus request is pending at that point.
- R8: A `frame_start` pulse while `frame_en` is high is ignored. The pixel total and the format sampled at the start of the frame stay in force until the frame ends.
- R9: Each word is one bus request. `bus_req` stays high, with `bus_data` and `bus_dc` unchanged, until the cycle in which `bus_ack` is high.
- R10: `pix_ready` is low whenever a bus write is pending.
- R11: `bus_dc` is 0 for a command word and 1 for a parameter word or a pixel word. `cmd_ready` is low while `frame_en` is high.
- R12: After reset, `frame_en`, `frame_done`, `bus_req` and `pix_ready` are low and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_fmt | input | 2 | Cycle format code, sampled at frame start |
| cfg_pix_total | input | CNT_W (16) | Pixels in the frame, sampled at frame start |
| frame_start | input | 1 | Sets the enable flag when idle |
| frame_en | output | 1 | Enable flag, cleared by the block at frame end |
| frame_done | output | 1 | One-cycle pulse at frame end |
| pix_valid | input | 1 | Upstream pixel valid |
| pix_ready | output | 1 | Pixel accepted when high together with pix_valid |
| pix_data | input | 3*BYTE_W (24) | Pixel value |
| cmd_valid | input | 1 | Single word write request |
| cmd_ready | output | 1 | Single word accepted when high together with cmd_valid |
| cmd_is_param | input | 1 | 1 = parameter word, 0 = command word |
| cmd_word | input | 2*BYTE_W (16) | Single word value |
| bus_req | output | 1 | Asks the strobe sequencer for one write cycle |
| bus_ack | input | 1 | Write cycle finished |
| bus_dc | output | 1 | Command/data select for the pending word |
| bus_data | output | 2*BYTE_W (16) | Pending bus word |

## Verification
The embedded assertions check the handshake rules on every cycle: a request is held stable until acknowledged, an accepted pixel or word always starts a request, commands are locked out during a frame, the frame counter never wraps, and the done pulse lasts one cycle and comes only out of an enabled frame with the bus idle. The actual byte order of each format, the odd-pixel padding in the 3:2 format, the exact number of pixels consumed and the immunity to a second start can only be shown by the bench. It replays whole frames against word lists it computes itself, with stalling upstream data and slow acknowledges.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

   typedef enum logic [1:0] {
      FMT_1X1 = 2'd0,
      FMT_2X1 = 2'd1,
      FMT_3X1 = 2'd2,
      FMT_3X2 = 2'd3
   } cyc_fmt_e;

   // index of the final word of one packing group for a format
   function automatic logic [1:0] last_phase_of(input cyc_fmt_e f);
      case (f)
         FMT_1X1: last_phase_of = 2'd0;
         FMT_2X1: last_phase_of = 2'd1;
         default: last_phase_of = 2'd2;
      endcase
   endfunction

endpackage

// File: rtl/pbp_pix_ctr.sv
module pbp_pix_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic             zero
);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

   logic [CNT_W-1:0] rem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rem_q <= '0;
      else if (load)
         rem_q <= load_val;
      else if (dec)
         rem_q <= rem_q - STEP;
   end

   assign zero = (rem_q == '0);

   // R6
   no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dec && !load |-> !zero);

   // R6
   load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (zero == ($past(load_val) == '0)));

endmodule

// File: rtl/pbp_word_slicer.sv
module pbp_word_slicer
   import pbp_pkg::*;
#(
   parameter int BYTE_W = 8,
   localparam int PIX_W = 3 * BYTE_W,
   localparam int BUS_W = 2 * BYTE_W
) (
   input  cyc_fmt_e         fmt,
   input  logic [1:0]       phase,
   input  logic             pad,
   input  logic [PIX_W-1:0] pix_in,
   input  logic [BUS_W-1:0] hold,
   output logic [BUS_W-1:0] word,
   output logic             last_phase
);
   localparam int PIX_LANES  = PIX_W / BYTE_W;
   localparam int HOLD_LANES = BUS_W / BYTE_W;
   localparam logic [BYTE_W-1:0] ZB = '0;

   logic [BYTE_W-1:0] in_b   [PIX_LANES];
   logic [BYTE_W-1:0] hold_b [HOLD_LANES];

   for (genvar g = 0; g < PIX_LANES; g++) begin : g_in_lane
      assign in_b[g] = pix_in[g*BYTE_W +: BYTE_W];
   end
   for (genvar g = 0; g < HOLD_LANES; g++) begin : g_hold_lane
      assign hold_b[g] = hold[g*BYTE_W +: BYTE_W];
   end

   always_comb begin
      word = '0;
      case (fmt)
         FMT_1X1: word = {in_b[1], in_b[0]};
         FMT_2X1: begin
            if (phase == 2'd0) word = {ZB, in_b[1]};
            else               word = {ZB, hold_b[0]};
         end
         FMT_3X1: begin
            if (phase == 2'd0)      word = {ZB, in_b[2]};
            else if (phase == 2'd1) word = {ZB, hold_b[1]};
            else                    word = {ZB, hold_b[0]};
         end
         FMT_3X2: begin
            if (phase == 2'd0)      word = {in_b[2], in_b[1]};
            else if (phase == 2'd1) word = {hold_b[0], pad ? ZB : in_b[2]};
            else                    word = {hold_b[1], hold_b[0]};
         end
         default: word = '0;
      endcase
   end

   assign last_phase = (phase == last_phase_of(fmt));

endmodule

// File: rtl/pbp_bus_port.sv
module pbp_bus_port #(
   parameter int BUS_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic [BUS_W-1:0] issue_word,
   input  logic             issue_dc,
   output logic             busy,
   output logic             bus_req,
   input  logic             bus_ack,
   output logic             bus_dc,
   output logic [BUS_W-1:0] bus_data
);
   logic             req_q;
   logic             dc_q;
   logic [BUS_W-1:0] data_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         dc_q   <= 1'b0;
         data_q <= '0;
      end else if (req_q) begin
         if (bus_ack) req_q <= 1'b0;
      end else if (issue) begin
         req_q  <= 1'b1;
         dc_q   <= issue_dc;
         data_q <= issue_word;
      end
   end

   assign busy     = req_q;
   assign bus_req  = req_q;
   assign bus_dc   = dc_q;
   assign bus_data = data_q;

   // R9
   req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_data) && $stable(bus_dc));

   // R9
   issue_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |-> !bus_req);

   // R9
   issue_starts_chk: assert property (@(posedge clk) disable iff (!rst_n)
      issue |=> bus_req && bus_data == $past(issue_word));

endmodule

// File: rtl/pixbus_packer.sv
module pixbus_packer
   import pbp_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int CNT_W  = 16,
   localparam int PIX_W = 3 * BYTE_W,
   localparam int BUS_W = 2 * BYTE_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       cfg_fmt,
   input  logic [CNT_W-1:0] cfg_pix_total,
   input  logic             frame_start,
   output logic             frame_en,
   output logic             frame_done,
   input  logic             pix_valid,
   output logic             pix_ready,
   input  logic [PIX_W-1:0] pix_data,
   input  logic             cmd_valid,
   output logic             cmd_ready,
   input  logic             cmd_is_param,
   input  logic [BUS_W-1:0] cmd_word,
   output logic             bus_req,
   input  logic             bus_ack,
   output logic             bus_dc,
   output logic [BUS_W-1:0] bus_data
);
   if (BYTE_W < 1) begin : g_bad_byte
      $error("pixbus_packer: BYTE_W must be at least 1");
   end
   if (CNT_W < 1) begin : g_bad_cnt
      $error("pixbus_packer: CNT_W must be at least 1");
   end

   logic             en_q;
   logic             done_q;
   cyc_fmt_e         fmt_q;
   logic [1:0]       phase_q;
   logic [BUS_W-1:0] hold_q;

   logic             busy;
   logic             rem_zero;
   logic             start_take;
   logic             need_pix;
   logic             pad;
   logic             pix_take;
   logic             frame_issue;
   logic             end_det;
   logic             cmd_take;
   logic             last_phase;
   logic [BUS_W-1:0] pix_word;
   logic [BUS_W-1:0] issue_word;
   logic             issue_dc;

   assign start_take = frame_start && !en_q;

   // a fresh pixel is needed at group start, and at the second word of 3:2
   assign need_pix = (phase_q == 2'd0) || (fmt_q == FMT_3X2 && phase_q == 2'd1);
   assign pad      = (fmt_q == FMT_3X2) && (phase_q == 2'd1) && rem_zero;

   assign pix_ready   = en_q && !busy && need_pix && !rem_zero;
   assign pix_take    = pix_ready && pix_valid;
   assign frame_issue = pix_take || (en_q && !busy && (pad || !need_pix));
   assign end_det     = en_q && !busy && (phase_q == 2'd0) && rem_zero;

   assign cmd_ready = !en_q && !busy && !frame_start;
   assign cmd_take  = cmd_ready && cmd_valid;

   assign issue_word = frame_issue ? pix_word : cmd_word;
   assign issue_dc   = frame_issue || cmd_is_param;

   pbp_word_slicer #(.BYTE_W(BYTE_W)) u_slicer (
      .fmt        (fmt_q),
      .phase      (phase_q),
      .pad        (pad),
      .pix_in     (pix_data),
      .hold       (hold_q),
      .word       (pix_word),
      .last_phase (last_phase)
   );

   pbp_pix_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start_take),
      .load_val (cfg_pix_total),
      .dec      (pix_take),
      .zero     (rem_zero)
   );

   pbp_bus_port #(.BUS_W(BUS_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue      (frame_issue || cmd_take),
      .issue_word (issue_word),
      .issue_dc   (issue_dc),
      .busy       (busy),
      .bus_req    (bus_req),
      .bus_ack    (bus_ack),
      .bus_dc     (bus_dc),
      .bus_data   (bus_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         done_q  <= 1'b0;
         fmt_q   <= FMT_1X1;
         phase_q <= 2'd0;
         hold_q  <= '0;
      end else begin
         done_q <= end_det;
         if (start_take) begin
            en_q    <= 1'b1;
            fmt_q   <= cyc_fmt_e'(cfg_fmt);
            phase_q <= 2'd0;
         end else if (end_det) begin
            en_q <= 1'b0;
         end else if (frame_issue) begin
            if (pad || last_phase) phase_q <= 2'd0;
            else                   phase_q <= phase_q + 2'd1;
         end
         if (pix_take) hold_q <= pix_data[BUS_W-1:0];
      end
   end

   assign frame_en   = en_q;
   assign frame_done = done_q;

   // R10
   pix_starts_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_valid && pix_ready |=> bus_req && bus_dc);

   // R11
   cmd_lockout_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_en |-> !cmd_ready);

   // R11
   cmd_dc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid && cmd_ready |=> bus_req && bus_dc == $past(cmd_is_param));

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |=> !frame_done);

   // R7
   done_clears_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> !frame_en && $past(frame_en) && !bus_req);

   // R8
   fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      frame_en && $past(frame_en) |-> $stable(fmt_q));

endmodule

// File: tb/tb_pixbus_packer.sv
`timescale 1ns/1ps
module tb_pixbus_packer;

   logic        clk;
   logic        rst_n;
   logic [1:0]  cfg_fmt;
   logic [15:0] cfg_pix_total;
   logic        frame_start;
   logic        frame_en;
   logic        frame_done;
   logic        pix_valid;
   logic        pix_ready;
   logic [23:0] pix_data;
   logic        cmd_valid;
   logic        cmd_ready;
   logic        cmd_is_param;
   logic [15:0] cmd_word;
   logic        bus_req;
   logic        bus_ack;
   logic        bus_dc;
   logic [15:0] bus_data;

   pixbus_packer dut (
      .clk(clk), .rst_n(rst_n), .cfg_fmt(cfg_fmt), .cfg_pix_total(cfg_pix_total),
      .frame_start(frame_start), .frame_en(frame_en), .frame_done(frame_done),
      .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_is_param(cmd_is_param),
      .cmd_word(cmd_word), .bus_req(bus_req), .bus_ack(bus_ack),
      .bus_dc(bus_dc), .bus_data(bus_data)
   );

   initial clk = 1'b0;
   always #10 clk = ~clk;

   int checks = 0;
   int fails  = 0;

   logic [15:0] log_w  [0:255];
   logic        log_dc [0:255];
   int          log_n     = 0;
   int          ack_dly   = 0;
   int          done_cnt  = 0;
   int          rdy_viol  = 0;
   int          cyc       = 0;
   int          feed_n    = 0;
   logic [7:0]  feed_seed = 8'h00;
   bit          feed_on   = 1'b0;
   bit          feed_bub  = 1'b0;
   int          idx       = 0;
   bit          acc_pend  = 1'b0;

   // fields: fmt[31:30] cnt[29:24] dly[23:22] bub[21] rekick[20] nw[15:8] seed[7:0]
   localparam int NV = 8;
   localparam logic [31:0] VEC [NV] = '{
      {2'd0, 6'd5, 2'd0, 1'b0, 1'b0, 4'd0, 8'd5, 8'h3A},
      {2'd1, 6'd4, 2'd1, 1'b1, 1'b0, 4'd0, 8'd8, 8'h51},
      {2'd2, 6'd3, 2'd2, 1'b0, 1'b0, 4'd0, 8'd9, 8'hC4},
      {2'd3, 6'd4, 2'd0, 1'b1, 1'b0, 4'd0, 8'd6, 8'h7E},
      {2'd3, 6'd5, 2'd1, 1'b0, 1'b0, 4'd0, 8'd8, 8'h92},
      {2'd3, 6'd1, 2'd0, 1'b0, 1'b0, 4'd0, 8'd2, 8'h0F},
      {2'd0, 6'd3, 2'd3, 1'b0, 1'b1, 4'd0, 8'd3, 8'h66},
      {2'd1, 6'd0, 2'd0, 1'b0, 1'b0, 4'd0, 8'd0, 8'hA5}
   };

   function automatic logic [23:0] gpix(input logic [7:0] s, input int i);
      logic [7:0] hi, mid, lo;
      hi  = s + 8'(i * 37);
      mid = (s * 8'd5) ^ 8'(i);
      lo  = 8'(i * 11) + s + 8'd1;
      return {hi, mid, lo};
   endfunction

   function automatic logic [15:0] expw(input logic [1:0] f, input logic [7:0] s,
                                        input int n, input int k);
      logic [23:0] a, b;
      case (f)
         2'd0: begin a = gpix(s, k); return a[15:0]; end
         2'd1: begin
            a = gpix(s, k / 2);
            return (k % 2 == 0) ? {8'h00, a[15:8]} : {8'h00, a[7:0]};
         end
         2'd2: begin
            a = gpix(s, k / 3);
            if (k % 3 == 0) return {8'h00, a[23:16]};
            if (k % 3 == 1) return {8'h00, a[15:8]};
            return {8'h00, a[7:0]};
         end
         default: begin
            a = gpix(s, 2 * (k / 3));
            b = gpix(s, 2 * (k / 3) + 1);
            if (k % 3 == 0) return a[23:8];
            if (k % 3 == 1) return {a[7:0], (2 * (k / 3) + 1 < n) ? b[23:16] : 8'h00};
            return b[15:0];
         end
      endcase
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // strobe sequencer model and monitor
   initial begin
      int wc;
      wc = 0;
      bus_ack = 1'b0;
      forever begin
         @(negedge clk);
         cyc++;
         if (frame_done) done_cnt++;
         if (bus_req && pix_ready) rdy_viol++;
         if (bus_ack) bus_ack = 1'b0;
         else if (bus_req) begin
            if (wc >= ack_dly) begin
               if (log_n < 256) begin
                  log_w[log_n]  = bus_data;
                  log_dc[log_n] = bus_dc;
               end
               log_n++;
               bus_ack = 1'b1;
               wc = 0;
            end else wc++;
         end
      end
   end

   // upstream pixel source
   initial begin
      pix_valid = 1'b0;
      pix_data  = '0;
      forever begin
         @(negedge clk);
         if (acc_pend) idx++;
         pix_valid = feed_on && (idx < feed_n) && !(feed_bub && (cyc % 3 == 1));
         pix_data  = gpix(feed_seed, idx);
         acc_pend  = pix_valid && pix_ready;
      end
   end

   task automatic run_frame(input logic [31:0] v);
      logic [1:0] f;
      int         n, nw, t;
      logic [7:0] s;
      bit         rek;
      string      tag;
      f   = v[31:30];
      n   = int'(v[29:24]);
      s   = v[7:0];
      nw  = int'(v[15:8]);
      rek = v[20];
      case (f)
         2'd0: tag = "R1";
         2'd1: tag = "R2";
         2'd2: tag = "R3";
         default: tag = (n % 2 == 1) ? "R5" : "R4";
      endcase
      @(negedge clk);
      log_n = 0; done_cnt = 0; idx = 0; acc_pend = 1'b0;
      ack_dly = int'(v[23:22]);
      feed_seed = s; feed_n = n + 4; feed_bub = v[21]; feed_on = 1'b1;
      cfg_fmt = f; cfg_pix_total = 16'(n); frame_start = 1'b1;
      @(negedge clk);
      frame_start = 1'b0;
      if (rek) begin
         repeat (4) @(negedge clk);
         // R11 command port locked during a frame
         chk(cmd_ready == 1'b0, "R11 cmd_ready in frame", 32'(cmd_ready), 32'd0);
         cfg_fmt = 2'd2; cfg_pix_total = 16'(n + 7); frame_start = 1'b1;
         @(negedge clk);
         frame_start = 1'b0;
      end
      t = 0;
      while (done_cnt == 0 && t < 3000) begin
         @(negedge clk);
         t++;
      end
      repeat (3) @(negedge clk);
      feed_on = 1'b0;
      if (rek) tag = "R8";
      if (n == 0) tag = "R6";
      chk(log_n == nw, {tag, " word count"}, 32'(log_n), 32'(nw));
      for (int k = 0; k < nw && k < log_n; k++) begin
         chk(log_w[k] == expw(f, s, n, k), {tag, " word value"}, 32'(log_w[k]),
             32'(expw(f, s, n, k)));
         chk(log_dc[k] == 1'b1, "R11 pixel select", 32'(log_dc[k]), 32'd1);
      end
      // R6 pixels consumed equals the sampled total
      chk(idx == n, "R6 pixels consumed", 32'(idx), 32'(n));
      // R7 enable cleared and one done pulse
      chk(frame_en == 1'b0, "R7 enable cleared", 32'(frame_en), 32'd0);
      chk(done_cnt == 1, "R7 done pulse count", 32'(done_cnt), 32'd1);
      chk(bus_req == 1'b0, "R7 bus idle", 32'(bus_req), 32'd0);
   endtask

   task automatic send_cmd(input logic [15:0] w, input bit param);
      int t;
      @(negedge clk);
      log_n = 0; ack_dly = 1;
      cmd_word = w; cmd_is_param = param; cmd_valid = 1'b1;
      t = 0;
      while (!cmd_ready && t < 100) begin
         @(negedge clk);
         t++;
      end
      @(negedge clk);
      cmd_valid = 1'b0;
      t = 0;
      while ((log_n == 0 || bus_req) && t < 100) begin
         @(negedge clk);
         t++;
      end
      repeat (2) @(negedge clk);
      // R9 one write per word
      chk(log_n == 1, "R9 single write", 32'(log_n), 32'd1);
      chk(log_w[0] == w, "R11 word value", 32'(log_w[0]), 32'(w));
      // R11 select line follows the word kind
      chk(log_dc[0] == param, "R11 select", 32'(log_dc[0]), 32'(param));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      cfg_fmt = 2'd0; cfg_pix_total = '0; frame_start = 1'b0;
      cmd_valid = 1'b0; cmd_is_param = 1'b0; cmd_word = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(frame_en == 1'b0,   "R12 frame_en",   32'(frame_en),   32'd0);
      chk(frame_done == 1'b0, "R12 frame_done", 32'(frame_done), 32'd0);
      chk(bus_req == 1'b0,    "R12 bus_req",    32'(bus_req),    32'd0);
      chk(pix_ready == 1'b0,  "R12 pix_ready",  32'(pix_ready),  32'd0);
      chk(cmd_ready == 1'b1,  "R12 cmd_ready",  32'(cmd_ready),  32'd1);

      send_cmd(16'h002C, 1'b0);
      send_cmd(16'hBEEF, 1'b1);

      for (int i = 0; i < NV; i++) run_frame(VEC[i]);

      // R10 no pixel accepted while a write is pending
      chk(rdy_viol == 0, "R10 ready during write", 32'(rdy_viol), 32'd0);

      send_cmd(16'h0029, 1'b0);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule